// File: doc/BRIEF.md
# Calibrated Real-Time Clock

This block keeps time of day (seconds, minutes and hours) from a free-running source clock that reaches it as a one-cycle tick enable. A two-bit select input tells the divider which of four source rates is feeding the ticks. The divider then counts that source's nominal number of ticks per half second. A signed trim value lengthens or shortens the second half of every second, which corrects for a fast or slow oscillator so that each second stays exact.

Software reaches the block through a small byte-wide register port with a combinational read path. It can read and write the time counters, the trim value and the interrupt enables. It can also read and clear the event flags. Five events are tracked: each half second, each second, each minute, each hour, and the day rollover. Each event has a sticky flag and an enable bit. The single interrupt line is raised while any enabled flag is set.

Top module: `rtc_core`

## Requirements
- R1: After reset the second, minute, hour, trim, enable and flag registers all read 0 and `irq` is low.
- R2: When the divider restarts, the first half-second boundary comes after exactly N source ticks and sets flag bit 0. N is `HALF_MAIN`, `HALF_SUB`, `HALF_RCS` or `HALF_RCF` for `src_sel` = 0, 1, 2 or 3.
- R3: One second spans 2*N + T source ticks, where T is the signed 8-bit trim at address 3. The trim is added to the second half only. At the end of the second, the seconds count advances and flag bits 0 and 1 are set.
- R4: Writing address 0, 1 or 2 clears the sub-second divider, so the next seconds advance comes a full calibrated second after the write.
- R5: Seconds run 0..59 at address 0 and minutes run 0..59 at address 1. A seconds wrap from 59 to 0 increments the minutes and sets flag bit 2.
- R6: Hours run 0..23 at address 2. A minutes wrap increments the hours and sets flag bit 3. An hours wrap from 23 to 0 also sets flag bit 4 (day).
- R7: A write of 60 or more to seconds or minutes, or of 24 or more to hours, is ignored. The register keeps its value.
- R8: The flags at address 5 are sticky. Writing 1 to a bit clears it, and writing 0 leaves it unchanged. A new event in the same cycle as a clear leaves the bit set.
- R9: `irq` is high exactly when some flag bit is set whose enable bit, at the same position in address 4, is also set.
- R10: The trim and enable registers (addresses 3 and 4) read back the value last written. Enable keeps its 5 low bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_tick | input | 1 | One-cycle enable per source clock period |
| src_sel | input | 2 | Source select: 0 main, 1 sub, 2 slow RC, 3 fast RC |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address for read and write |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data for `addr`, combinational |
| irq | output | 1 | Interrupt, OR of enabled flags |

## Verification
The divider is driven with all four source selects, with zero, positive and negative trims. Two tick counts are checked for each setting: the count to the half-second flag and the count to the seconds advance. Together they separate an error in the nominal reload from an error in where the trim is applied. A restart in the middle of a count separates a divider that is cleared on time writes from one that keeps running. Loading 23:59:59 before the full rollover, and 05:59 before a minute-only carry, shows that each carry stops at the right level.

// File: rtl/rtc_core.sv
module rtc_core #(
  parameter int CNT_W     = 22,
  parameter int HALF_MAIN = 2000000,
  parameter int HALF_SUB  = 16384,
  parameter int HALF_RCS  = 50000,
  parameter int HALF_RCF  = 1000000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       src_tick,
  input  logic [1:0] src_sel,
  input  logic       wr_en,
  input  logic [2:0] addr,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  output logic       irq
);
  localparam int NFLAG = 5;

  logic [CNT_W-1:0] cnt_q, nom, len;
  logic             phase_q;
  logic [5:0]       sec_q, min_q;
  logic [4:0]       hr_q;
  logic [7:0]       trim_q;
  logic [NFLAG-1:0] en_q, flag_q, ev, clr;
  logic             time_wr, at_end, half_ev, sec_ev, min_ev, hr_ev, day_ev;

  always_comb begin
    case (src_sel)
      2'd0:    nom = CNT_W'(HALF_MAIN);
      2'd1:    nom = CNT_W'(HALF_SUB);
      2'd2:    nom = CNT_W'(HALF_RCS);
      default: nom = CNT_W'(HALF_RCF);
    endcase
  end

  assign len     = phase_q ? nom + {{(CNT_W-8){trim_q[7]}}, trim_q} : nom;
  assign time_wr = wr_en && (addr <= 3'd2);
  assign at_end  = src_tick && (cnt_q == len - 1'b1);
  assign half_ev = at_end && !time_wr;
  assign sec_ev  = half_ev && phase_q;
  assign min_ev  = sec_ev && (sec_q == 6'd59);
  assign hr_ev   = min_ev && (min_q == 6'd59);
  assign day_ev  = hr_ev && (hr_q == 5'd23);
  assign ev      = {day_ev, hr_ev, min_ev, sec_ev, half_ev};
  assign clr     = (wr_en && addr == 3'd5) ? wr_data[NFLAG-1:0] : '0;
  assign irq     = |(flag_q & en_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      phase_q <= 1'b0;
    end else if (time_wr) begin
      cnt_q   <= '0;
      phase_q <= 1'b0;
    end else if (at_end) begin
      cnt_q   <= '0;
      phase_q <= ~phase_q;
    end else if (src_tick) begin
      cnt_q   <= cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec_q  <= '0;
      min_q  <= '0;
      hr_q   <= '0;
      trim_q <= '0;
      en_q   <= '0;
      flag_q <= '0;
    end else begin
      if (wr_en && addr == 3'd0) begin
        if (wr_data < 8'd60) sec_q <= wr_data[5:0];
      end else if (sec_ev) begin
        sec_q <= min_ev ? 6'd0 : sec_q + 1'b1;
      end
      if (wr_en && addr == 3'd1) begin
        if (wr_data < 8'd60) min_q <= wr_data[5:0];
      end else if (min_ev) begin
        min_q <= hr_ev ? 6'd0 : min_q + 1'b1;
      end
      if (wr_en && addr == 3'd2) begin
        if (wr_data < 8'd24) hr_q <= wr_data[4:0];
      end else if (hr_ev) begin
        hr_q <= day_ev ? 5'd0 : hr_q + 1'b1;
      end
      if (wr_en && addr == 3'd3) trim_q <= wr_data;
      if (wr_en && addr == 3'd4) en_q <= wr_data[NFLAG-1:0];
      flag_q <= (flag_q & ~clr) | ev;
    end
  end

  always_comb begin
    case (addr)
      3'd0:    rd_data = {2'b0, sec_q};
      3'd1:    rd_data = {2'b0, min_q};
      3'd2:    rd_data = {3'b0, hr_q};
      3'd3:    rd_data = trim_q;
      3'd4:    rd_data = {3'b0, en_q};
      3'd5:    rd_data = {3'b0, flag_q};
      default: rd_data = 8'd0;
    endcase
  end

  // R5
  sec_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sec_q <= 6'd59 && min_q <= 6'd59);

  // R6
  hr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hr_q <= 5'd23);

  // R6
  day_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    day_ev |=> (hr_q == 5'd0 && min_q == 6'd0 && sec_q == 6'd0 && flag_q[4]));

  // R7
  bad_sec_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 3'd0 && wr_data >= 8'd60) |=> $stable(sec_q));

  // R8
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 3'd5 && wr_data[1] && !sec_ev) |=> !flag_q[1]);

  // R4
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    time_wr |=> !phase_q && $stable(sec_q) || $past(addr) == 3'd0);
endmodule

// File: tb/rtc_core_test.sv
module rtc_core_test;
  localparam int HM = 20, HS = 16, HR = 10, HF = 25;
  logic       clk = 0, rst_n = 0, src_tick = 0, wr_en = 0;
  logic [1:0] src_sel = 0;
  logic [2:0] addr = 0;
  logic [7:0] wr_data = 0, rd_data;
  logic       irq;
  int n_chk = 0, n_bad = 0;

  rtc_core #(.CNT_W(8), .HALF_MAIN(HM), .HALF_SUB(HS), .HALF_RCS(HR), .HALF_RCF(HF)) uut (
    .clk(clk), .rst_n(rst_n), .src_tick(src_tick), .src_sel(src_sel), .wr_en(wr_en),
    .addr(addr), .wr_data(wr_data), .rd_data(rd_data), .irq(irq));

  always #4 clk = ~clk;

  // {sel, trim, ticks to half, ticks to second}
  typedef struct packed { logic [1:0] sel; logic [7:0] trim; logic [7:0] half; logic [7:0] full; } vec_t;
  localparam vec_t VECS [5] = '{
    '{2'd0, 8'd0,   8'd20, 8'd40},
    '{2'd1, 8'd5,   8'd16, 8'd37},
    '{2'd2, 8'hFD,  8'd10, 8'd17},
    '{2'd3, 8'd0,   8'd25, 8'd50},
    '{2'd1, 8'hF9,  8'd16, 8'd25}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1; addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    addr = a; #1 d = rd_data;
  endtask

  task automatic tick();
    @(negedge clk); src_tick = 1;
    @(negedge clk); src_tick = 0;
  endtask

  task automatic ticks_to_sec(input logic [7:0] start, output int n);
    logic [7:0] v;
    n = 0;
    do begin
      tick(); n++; rd(3'd0, v);
    end while (v == start && n < 200);
  endtask

  initial begin
    #1_000_000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] v;
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    for (int a = 0; a < 6; a++) begin rd(3'(a), v); check("R1", v, 8'd0); end
    check("R1 irq", {7'd0, irq}, 8'd0);

    // R2 R3 table walk
    foreach (VECS[i]) begin
      src_sel = VECS[i].sel;
      wr(3'd3, VECS[i].trim);
      wr(3'd0, 8'd0);
      wr(3'd5, 8'h1F);
      for (int k = 0; k < int'(VECS[i].half); k++) tick();
      rd(3'd5, v); check("R2 half flag", v, 8'h01);
      ticks_to_sec(8'd0, n);
      check("R3 ticks per second", 8'(n + int'(VECS[i].half)), VECS[i].full);
      rd(3'd5, v); check("R3 flags", v, 8'h03);
    end

    // R10 readback
    src_sel = 0;
    wr(3'd3, 8'd0);
    wr(3'd4, 8'hFF);
    rd(3'd4, v); check("R10 enable", v, 8'h1F);
    rd(3'd3, v); check("R10 trim", v, 8'd0);

    // R4 restart mid-count
    for (int k = 0; k < 15; k++) tick();
    wr(3'd0, 8'd10);
    ticks_to_sec(8'd10, n);
    check("R4 restart", 8'(n), 8'd40);

    // R6 full rollover
    wr(3'd2, 8'd23); wr(3'd1, 8'd59); wr(3'd0, 8'd59);
    wr(3'd5, 8'h1F);
    for (int k = 0; k < 2 * HM; k++) tick();
    rd(3'd0, v); check("R5 sec wrap", v, 8'd0);
    rd(3'd1, v); check("R5 min wrap", v, 8'd0);
    rd(3'd2, v); check("R6 hour wrap", v, 8'd0);
    rd(3'd5, v); check("R6 flags", v, 8'h1F);
    check("R9 irq on", {7'd0, irq}, 8'd1);
    wr(3'd4, 8'd0);
    check("R9 irq masked", {7'd0, irq}, 8'd0);

    // R8 write-1-clear
    wr(3'd5, 8'h02);
    rd(3'd5, v); check("R8 w1c", v, 8'h1D);
    wr(3'd5, 8'h00);
    rd(3'd5, v); check("R8 zero keeps", v, 8'h1D);
    wr(3'd4, 8'h04);
    check("R9 single enable", {7'd0, irq}, 8'd1);
    wr(3'd5, 8'h1F);
    check("R9 cleared", {7'd0, irq}, 8'd0);

    // R7 out-of-range writes
    wr(3'd1, 8'd60); rd(3'd1, v); check("R7 min", v, 8'd0);
    wr(3'd2, 8'd24); rd(3'd2, v); check("R7 hour", v, 8'd0);
    wr(3'd0, 8'd75); rd(3'd0, v); check("R7 sec", v, 8'd0);

    // R5 minute carry without hour carry
    wr(3'd1, 8'd5); wr(3'd0, 8'd59);
    for (int k = 0; k < 2 * HM; k++) tick();
    rd(3'd1, v); check("R5 min carry", v, 8'd6);
    rd(3'd2, v); check("R5 hour kept", v, 8'd0);
    rd(3'd5, v); check("R5 flags", v, 8'h07);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule